// File: doc/BRIEF.md
# Two-Level Warp Issue Scheduler

This block picks at most one warp per clock for issue out of a fixed pool. The pool is cut into equal groups of consecutive warp numbers, and only one group is allowed to issue at a time. Inside that group, a single rotating pointer chooses the next warp that is ready and not held by a long-latency memory access. The pointer then moves to the slot after the warp it chose, so the same warp can be followed by a different one on the very next clock. No context is saved or restored between warps.

Each warp has two input bits. The ready bit comes from the upstream decode and scoreboard logic. The stall bit is set while the warp waits on a long-latency load and clears when the data comes back. The scheduler leaves the active group only when every warp in that group has its stall bit set. It then looks for the next group, in circular order after the current one, that holds a warp it can issue. The issue decision depends only on the present inputs and on two state registers, so the chosen warp is valid in the same cycle as the inputs. The state registers are updated at the clock edge.

Top module: `twoLevelWarpSched`

## Requirements
- R1: A synchronous reset makes group 0 active and sets the in-group pointer to slot 0. Warp number w is bit w of each per-warp vector and equals group*GROUP_SIZE + slot.
- R2: `issueValid` is high only for a warp whose ready bit is 1 and whose stall bit is 0. `issueWarp` carries that warp's number.
- R3: Inside the active group, the warp chosen is the first issuable slot at or after the pointer, wrapping from the last slot to slot 0. A different warp may be chosen on consecutive cycles.
- R4: After each issue, the pointer holds the slot after the issued one, modulo GROUP_SIZE.
- R5: While any warp of the active group has its stall bit clear, no other group issues. If that group has nothing issuable, `issueValid` is 0, even when other groups have ready warps.
- R6: When every warp of the active group is stalled, the scheduler looks at groups active+1, active+2, ... in circular order. It activates the first one that holds an issuable warp and issues from it in the same cycle, scanning from slot 0.
- R7: When nothing can issue, `issueValid` is 0, and both the active group and the pointer keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| readyBits | input | NUM_WARPS | Per-warp ready flags |
| stallBits | input | NUM_WARPS | Per-warp long-latency wait flags |
| issueValid | output | 1 | A warp is chosen this cycle |
| issueWarp | output | log2(NUM_WARPS) | Number of the chosen warp |

## Verification
The bench builds the block with its defaults: 16 warps in 4 groups of 4. With these values, a few steps are enough to wrap the in-group pointer from slot 3 back to 0. They also reach the circular group search from group 3 back to group 0, where a later group with eligible warps must lose to the nearer one. Four groups also leave room for a run that skips two fully stalled groups before it finds an eligible one. A reset is applied after the active group has left group 0, to show that the group and the pointer both return to zero.

// File: rtl/twoLevelSchedPkg.sv
package twoLevelSchedPkg;
  // Strobes the control hands to the datapath each cycle
  typedef struct packed {
    logic issueActive;  // issue from the current group
    logic switchGroup;  // move to targetGroup and issue from it
  } schedStrobe_t;
endpackage

// File: rtl/schedControl.sv
module schedControl
  import twoLevelSchedPkg::*;
#(
  parameter int NUM_GROUPS = 4,
  localparam int GROUP_W = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [GROUP_W-1:0]    activeGroup,
  input  logic [NUM_GROUPS-1:0] groupHasEligible,
  input  logic                  activeAllStalled,
  output schedStrobe_t          strobe,
  output logic [GROUP_W-1:0]    targetGroup
);

  logic searchFound;

  // Circular search over the other groups, nearest first
  always_comb begin
    searchFound = 1'b0;
    targetGroup = activeGroup;
    for (int k = 1; k < NUM_GROUPS; k++) begin
      logic [GROUP_W-1:0] cand;
      cand = GROUP_W'(int'(activeGroup) + k);
      if (!searchFound && groupHasEligible[cand]) begin
        searchFound = 1'b1;
        targetGroup = cand;
      end
    end
  end

  always_comb begin
    strobe.issueActive = groupHasEligible[activeGroup];
    strobe.switchGroup = !groupHasEligible[activeGroup] && activeAllStalled && searchFound;
  end

  // R6: a switch always lands on another group that can issue
  p_switch_target_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.switchGroup |-> (groupHasEligible[targetGroup] && targetGroup != activeGroup));

endmodule

// File: rtl/schedDatapath.sv
module schedDatapath
  import twoLevelSchedPkg::*;
#(
  parameter int NUM_WARPS  = 16,
  parameter int GROUP_SIZE = 4,
  localparam int NUM_GROUPS = NUM_WARPS / GROUP_SIZE,
  localparam int GROUP_W    = $clog2(NUM_GROUPS),
  localparam int SLOT_W     = $clog2(GROUP_SIZE),
  localparam int WARP_W     = $clog2(NUM_WARPS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_WARPS-1:0]  readyBits,
  input  logic [NUM_WARPS-1:0]  stallBits,
  input  schedStrobe_t          strobe,
  input  logic [GROUP_W-1:0]    targetGroup,
  output logic [NUM_GROUPS-1:0] groupHasEligible,
  output logic                  activeAllStalled,
  output logic [GROUP_W-1:0]    activeGroup,
  output logic                  issueValid,
  output logic [WARP_W-1:0]     issueWarp
);

  logic [NUM_WARPS-1:0]  eligible;
  logic [NUM_GROUPS-1:0] groupAllStalled;
  logic [SLOT_W-1:0]     rrPtr;
  logic [GROUP_W-1:0]    selGroup;
  logic [SLOT_W-1:0]     basePtr;
  logic [GROUP_SIZE-1:0] selBits;
  logic [SLOT_W-1:0]     pickSlot;
  logic                  pickFound;

  assign eligible = readyBits & ~stallBits;

  // Per-group summaries
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    assign groupHasEligible[g] = |eligible[g*GROUP_SIZE +: GROUP_SIZE];
    assign groupAllStalled[g]  = &stallBits[g*GROUP_SIZE +: GROUP_SIZE];
  end

  assign activeAllStalled = groupAllStalled[activeGroup];

  // A newly activated group scans from slot 0
  assign selGroup = strobe.switchGroup ? targetGroup : activeGroup;
  assign basePtr  = strobe.switchGroup ? '0 : rrPtr;
  assign selBits  = eligible[int'(selGroup)*GROUP_SIZE +: GROUP_SIZE];

  always_comb begin
    pickFound = 1'b0;
    pickSlot  = '0;
    for (int k = 0; k < GROUP_SIZE; k++) begin
      logic [SLOT_W-1:0] slot;
      slot = SLOT_W'(int'(basePtr) + k);
      if (!pickFound && selBits[slot]) begin
        pickFound = 1'b1;
        pickSlot  = slot;
      end
    end
  end

  assign issueValid = (strobe.issueActive || strobe.switchGroup) && pickFound;
  assign issueWarp  = {selGroup, pickSlot};

  always_ff @(posedge clk) begin
    if (rst) begin
      activeGroup <= '0;
      rrPtr       <= '0;
    end else if (issueValid) begin
      activeGroup <= selGroup;
      rrPtr       <= pickSlot + SLOT_W'(1);
    end
  end

  // R2: the issued warp is ready and not stalled
  p_issue_eligible_r2: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> (readyBits[issueWarp] && !stallBits[issueWarp]));

  // R4: the pointer follows the issued slot
  p_ptr_next_r4: assert property (@(posedge clk) disable iff (rst)
    issueValid |=> (rrPtr == SLOT_W'($past(issueWarp[SLOT_W-1:0]) + 1)));

  // R5: the group is held while any of its warps is unstalled
  p_hold_group_r5: assert property (@(posedge clk) disable iff (rst)
    !activeAllStalled |=> $stable(activeGroup));

  // R7: idle cycles leave the state alone
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !issueValid |=> ($stable(activeGroup) && $stable(rrPtr)));

endmodule

// File: rtl/twoLevelWarpSched.sv
module twoLevelWarpSched
  import twoLevelSchedPkg::*;
#(
  parameter int NUM_WARPS  = 16,
  parameter int GROUP_SIZE = 4,
  localparam int NUM_GROUPS = NUM_WARPS / GROUP_SIZE,
  localparam int GROUP_W    = $clog2(NUM_GROUPS),
  localparam int WARP_W     = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] readyBits,
  input  logic [NUM_WARPS-1:0] stallBits,
  output logic                 issueValid,
  output logic [WARP_W-1:0]    issueWarp
);

  schedStrobe_t          strobe;
  logic [GROUP_W-1:0]    targetGroup;
  logic [GROUP_W-1:0]    activeGroup;
  logic [NUM_GROUPS-1:0] groupHasEligible;
  logic                  activeAllStalled;

  schedControl #(.NUM_GROUPS(NUM_GROUPS)) ctrl_i (
    .clk              (clk),
    .rst              (rst),
    .activeGroup      (activeGroup),
    .groupHasEligible (groupHasEligible),
    .activeAllStalled (activeAllStalled),
    .strobe           (strobe),
    .targetGroup      (targetGroup)
  );

  schedDatapath #(.NUM_WARPS(NUM_WARPS), .GROUP_SIZE(GROUP_SIZE)) dp_i (
    .clk              (clk),
    .rst              (rst),
    .readyBits        (readyBits),
    .stallBits        (stallBits),
    .strobe           (strobe),
    .targetGroup      (targetGroup),
    .groupHasEligible (groupHasEligible),
    .activeAllStalled (activeAllStalled),
    .activeGroup      (activeGroup),
    .issueValid       (issueValid),
    .issueWarp        (issueWarp)
  );

endmodule

// File: tb/twoLevelWarpSched_tb.sv
module twoLevelWarpSched_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] readyBits = '0;
  logic [15:0] stallBits = '0;
  logic        issueValid;
  logic [3:0]  issueWarp;
  int          testCount = 0;
  int          failCount = 0;
  bit          benchDone = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  twoLevelWarpSched dut_i (
    .clk        (clk),
    .rst        (rst),
    .readyBits  (readyBits),
    .stallBits  (stallBits),
    .issueValid (issueValid),
    .issueWarp  (issueWarp)
  );

  // {ready[36:21], stall[20:5], expValid[4], expWarp[3:0]}, applied in order from reset
  localparam logic [36:0] VEC [16] = '{
    {16'hFFFF, 16'h0000, 1'b1, 4'd0},   // R1 first issue is group 0 slot 0
    {16'hFFFF, 16'h0000, 1'b1, 4'd1},   // R3 a new warp on the next cycle
    {16'h0009, 16'h0000, 1'b1, 4'd3},   // R3 skip slot 2, take slot 3
    {16'h0009, 16'h0000, 1'b1, 4'd0},   // R4 pointer wrapped to slot 0
    {16'h00F0, 16'h0000, 1'b0, 4'd0},   // R5 group 0 not stalled, stay idle
    {16'h00F0, 16'h000E, 1'b0, 4'd0},   // R5 one unstalled warp still holds group 0
    {16'h00F0, 16'h000F, 1'b1, 4'd4},   // R6 switch to group 1, slot 0
    {16'h00F0, 16'h000F, 1'b1, 4'd5},   // R4 pointer now slot 1
    {16'h0F00, 16'h00FF, 1'b1, 4'd8},   // R6 group 1 stalled, move to group 2
    {16'hF00F, 16'h0FFF, 1'b1, 4'd12},  // R6 group 2 stalled, move to group 3
    {16'h0F02, 16'hF000, 1'b1, 4'd1},   // R6 circular search wraps to group 0 before group 2
    {16'h0000, 16'h0000, 1'b0, 4'd0},   // R7 nothing ready
    {16'hFFFF, 16'hFFFF, 1'b0, 4'd0},   // R7 everything stalled
    {16'h000F, 16'h0000, 1'b1, 4'd2},   // R7 pointer kept at slot 2 over idle cycles
    {16'h000F, 16'h0000, 1'b1, 4'd3},   // R3
    {16'h000F, 16'h0000, 1'b1, 4'd0}    // R4 wrap
  };
  string vecReq [16] = '{"R1", "R3", "R3", "R4", "R5", "R5", "R6", "R4",
                         "R6", "R6", "R6", "R7", "R7", "R7", "R3", "R4"};

  task automatic checkVal(input string req, input int actual, input int expected);
    testCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Drive at negedge, check the combinational result before the next rising edge
  task automatic applyCheck(input logic [15:0] rdy, input logic [15:0] stl,
                            input bit expV, input int expW, input string req);
    @(negedge clk);
    readyBits = rdy;
    stallBits = stl;
    #5;
    checkVal({req, " valid"}, int'(issueValid), int'(expV));
    if (expV) checkVal({req, " warp"}, int'(issueWarp), expW);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #5;
    checkVal("R7 idle out of reset", int'(issueValid), 0);

    for (int i = 0; i < 16; i++) begin
      applyCheck(VEC[i][36:21], VEC[i][20:5], VEC[i][4], int'(VEC[i][3:0]), vecReq[i]);
    end

    // Move away from group 0, then reset mid-run
    applyCheck(16'h0F00, 16'h00FF, 1'b1, 8, "R6 pre-reset switch to group 2");
    @(negedge clk);
    rst = 1'b1;
    readyBits = '0;
    stallBits = '0;
    @(negedge clk);
    rst = 1'b0;
    // R1: group 2 ready but group 0 unstalled, so group 0 must be active
    readyBits = 16'h0F00;
    #5;
    checkVal("R1 group 0 active after reset", int'(issueValid), 0);
    applyCheck(16'hFFFF, 16'h0000, 1'b1, 0, "R1 pointer at slot 0 after reset");
    applyCheck(16'hFFFF, 16'h0000, 1'b1, 1, "R2 back-to-back issue");
    applyCheck(16'hFFFF, 16'h0006, 1'b1, 3, "R2 stalled ready warps skipped");

    benchDone = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!benchDone) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule